// File: doc/BRIEF.md
# Instruction TLB Replacement-Order Tracker

This block keeps the usage history of a four-way, fully associative instruction translation cache. The history is a 6-bit pairwise-order word. Each bit records which of two ways was used more recently. A hit on a way updates the word, and so does a refill into a way. When a miss has to be filled from the larger unified table, the block names the way to overwrite.

The history also sits in a 6-bit field of the MMU control word. Software can load that field, and the rest of the control word passes through the block unchanged. Some history patterns match none of the victim rules. When the history holds one of these, the block raises a flag at once. A refill request made while the history is in that state is answered with an error and leaves the history as it is.

All pins are plain control and status strobes. There is no back-pressure on any of them. Each strobe is acted on in the cycle it is high. A refill answer appears on the cycle after its request.

Top module: `itlb_lru_tracker`

## Requirements
- R1: After reset, `hist` is 0, `victim_vld` and `victim_err` are 0, and `hist_bad` is 0.
- R2: When `cfg_wr` is high, `hist` takes `cfg_wdata[31:26]` at the next edge. The other bits of `cfg_wdata` are ignored. In the same cycle, a write takes precedence over a refill and over a touch for the history value.
- R3: `ctl_out[25:0]` always equals `ctl_in[25:0]`, and `ctl_out[31:26]` always equals `hist`.
- R4: The victim rules are tested in order, and the first rule that matches names the way:
  - way 0 is chosen when bits 5, 4 and 3 are all 1;
  - way 1 is chosen when bit 5 is 0 and bits 2 and 1 are both 1;
  - way 2 is chosen when bits 4 and 2 are 0 and bit 0 is 1;
  - way 3 is chosen when bits 3, 1 and 0 are all 0.
- R5: `hist_bad` is high, in the same cycle, exactly when the current history matches none of the R4 rules.
- R6: A touch of way k (`touch_vld` high with `touch_idx` = k) changes the history as follows, and only these bits change:
  - way 0 clears bits 5:3;
  - way 1 sets bit 5 and clears bits 2:1;
  - way 2 sets bits 4 and 2 and clears bit 0;
  - way 3 sets bits 3, 1 and 0.
- R7: A `refill_req` makes `victim_vld` pulse high on the next cycle, with `victim_idx` holding the R4 choice for the history as it was at the request. The history is then updated as a touch of that way. If the history was bad, `victim_err` is 1, `victim_idx` is 0, and the history is unchanged.
- R8: When `refill_req` and `touch_vld` are high in the same cycle, the touch is ignored.
- R9: When no write, touch or refill occurs, `hist` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| touch_vld | input | 1 | Hit strobe for one way |
| touch_idx | input | 2 | Way that was hit |
| refill_req | input | 1 | Ask for a victim and fill it |
| cfg_wr | input | 1 | Software write of the control word |
| cfg_wdata | input | 32 | Control word written by software; bits 31:26 carry the history |
| ctl_in | input | 32 | Control word from its owner register |
| ctl_out | output | 32 | `ctl_in` with the history merged into bits 31:26 |
| hist | output | 6 | Current history |
| hist_bad | output | 1 | History matches no victim rule |
| victim_vld | output | 1 | Refill answer valid |
| victim_idx | output | 2 | Way chosen for refill |
| victim_err | output | 1 | Refill request was made with a bad history |

## Verification
The assertions take for granted that `touch_idx` is only meaningful while `touch_vld` is high. They also assume software may write any 6-bit pattern at any time, including patterns that no sequence of touches can reach. The stimulus loads every one of the 64 patterns through the write path before it refills or touches. This covers both the illegal states and the priority between rules. Strobes are raised for a single cycle, and they are combined in the same cycle only in the checks that target precedence.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned HIST_W = 6;

  typedef logic [HIST_W-1:0] hist_t;
  typedef logic [IDX_W-1:0]  way_t;

  // Bits a touch of way w forces to 1.
  function automatic hist_t touch_set(int unsigned w);
    case (w)
      0:       return 6'b000000;
      1:       return 6'b100000;
      2:       return 6'b010100;
      default: return 6'b001011;
    endcase
  endfunction

  // Bits a touch of way w forces to 0.
  function automatic hist_t touch_clr(int unsigned w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b000110;
      2:       return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  // Bits examined by the victim rule of way w.
  function automatic hist_t rule_care(int unsigned w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b100110;
      2:       return 6'b010101;
      default: return 6'b001011;
    endcase
  endfunction

  // Values those bits must have.
  function automatic hist_t rule_want(int unsigned w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b000110;
      2:       return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import itlb_lru_pkg::*;
(
  input  hist_t hist_i,
  output way_t  way_o,
  output logic  none_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_rule
    assign match[w] = ((hist_i & rule_care(w)) == rule_want(w));
  end

  // Lowest-numbered matching rule wins.
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = way_t'(w);
    end
  end

  assign none_o = ~|match;
endmodule

// File: rtl/lru_hist_next.sv
module lru_hist_next
  import itlb_lru_pkg::*;
(
  input  hist_t hist_i,
  input  way_t  way_i,
  output hist_t hist_o
);
  hist_t cand [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign cand[w] = (hist_i & ~touch_clr(w)) | touch_set(w);
  end

  assign hist_o = cand[way_i];
endmodule

// File: rtl/lru_hist_reg.sv
module lru_hist_reg
  import itlb_lru_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  hist_t ld_val,
  input  logic  upd_en,
  input  hist_t upd_val,
  output hist_t hist_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q <= '0;
    else if (ld_en)  hist_q <= ld_val;
    else if (upd_en) hist_q <= upd_val;
  end

  // R9: no load and no update leaves the history unchanged.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !upd_en) |=> $stable(hist_q));
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
  import itlb_lru_pkg::*;
#(
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned HIST_LSB = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_vld,
  input  logic [1:0]       touch_idx,
  input  logic             refill_req,
  input  logic             cfg_wr,
  input  logic [CTL_W-1:0] cfg_wdata,
  input  logic [CTL_W-1:0] ctl_in,
  output logic [CTL_W-1:0] ctl_out,
  output logic [5:0]       hist,
  output logic             hist_bad,
  output logic             victim_vld,
  output logic [1:0]       victim_idx,
  output logic             victim_err
);
  localparam int unsigned HIST_MSB = HIST_LSB + HIST_W - 1;

  hist_t hist_q, hist_upd;
  way_t  pick_way, upd_way;
  logic  pick_none, upd_en;

  lru_victim_pick u_pick (
    .hist_i (hist_q),
    .way_o  (pick_way),
    .none_o (pick_none)
  );

  // A refill takes the way slot ahead of a plain touch.
  assign upd_way = refill_req ? pick_way : touch_idx;
  assign upd_en  = refill_req ? ~pick_none : touch_vld;

  lru_hist_next u_next (
    .hist_i (hist_q),
    .way_i  (upd_way),
    .hist_o (hist_upd)
  );

  lru_hist_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (cfg_wr),
    .ld_val  (cfg_wdata[HIST_MSB:HIST_LSB]),
    .upd_en  (upd_en),
    .upd_val (hist_upd),
    .hist_q  (hist_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_vld <= 1'b0;
      victim_idx <= '0;
      victim_err <= 1'b0;
    end else begin
      victim_vld <= refill_req;
      victim_idx <= (refill_req && !pick_none) ? pick_way : '0;
      victim_err <= refill_req && pick_none;
    end
  end

  always_comb begin
    ctl_out = ctl_in;
    ctl_out[HIST_MSB:HIST_LSB] = hist_q;
  end

  assign hist     = hist_q;
  assign hist_bad = pick_none;

  // R2: a software write lands in the history on the next edge.
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (hist_q == $past(cfg_wdata[HIST_MSB:HIST_LSB])));

  // R6: a way just touched is no longer the victim.
  a_r6_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_vld && !refill_req && !cfg_wr) |=> (pick_none || pick_way != $past(touch_idx)));

  // R7: every refill request is answered one cycle later, and only then.
  a_r7_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> victim_vld);
  a_r7_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_req |=> !victim_vld);

  // R7: a refill on a bad history reports an error and keeps the history.
  a_r7_bad_refill_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && pick_none && !cfg_wr) |=> ($stable(hist_q) && victim_err));

  // R7: the way just refilled is not chosen again straight away.
  a_r7_refilled_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !pick_none && !cfg_wr) |=> (pick_none || pick_way != victim_idx));
endmodule

// File: tb/sim_itlb_lru_tracker.sv
module sim_itlb_lru_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        touch_vld = 1'b0;
  logic [1:0]  touch_idx = '0;
  logic        refill_req = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctl_in = '0;
  logic [31:0] ctl_out;
  logic [5:0]  hist;
  logic        hist_bad, victim_vld, victim_err;
  logic [1:0]  victim_idx;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  itlb_lru_tracker u0 (
    .clk(clk), .rst_n(rst_n), .touch_vld(touch_vld), .touch_idx(touch_idx),
    .refill_req(refill_req), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctl_in(ctl_in), .ctl_out(ctl_out), .hist(hist), .hist_bad(hist_bad),
    .victim_vld(victim_vld), .victim_idx(victim_idx), .victim_err(victim_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference victim choice, written from the bit rules.
  function automatic int ref_victim(logic [5:0] h);
    if (h[5] && h[4] && h[3])   return 0;
    if (!h[5] && h[2] && h[1])  return 1;
    if (!h[4] && !h[2] && h[0]) return 2;
    if (!h[3] && !h[1] && !h[0]) return 3;
    return -1;
  endfunction

  function automatic logic [5:0] ref_touch(logic [5:0] h, int w);
    logic [5:0] r = h;
    case (w)
      0: r[5:3] = 3'b000;
      1: begin r[5] = 1'b1; r[2:1] = 2'b00; end
      2: begin r[4] = 1'b1; r[2] = 1'b1; r[0] = 1'b0; end
      default: begin r[3] = 1'b1; r[1] = 1'b1; r[0] = 1'b1; end
    endcase
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    touch_vld = 1'b0; refill_req = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic load(logic [5:0] h);
    cfg_wr = 1'b1;
    cfg_wdata = {h, 26'h2A5_5A3C ^ {20'd0, h}};
    step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hist", 32'(hist), 32'h0);
    check("R1 victim_vld", 32'(victim_vld), 32'h0);
    check("R1 victim_err", 32'(victim_err), 32'h0);
    check("R1 hist_bad", 32'(hist_bad), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int h = 0; h < 64; h++) begin
      int v;
      v = ref_victim(6'(h));
      ctl_in = 32'hFFFF_FFFF ^ (32'(h) * 32'h0101_0337);
      load(6'(h));
      check("R2 write", 32'(hist), 32'(h));
      check("R3 merge", ctl_out, {6'(h), ctl_in[25:0]});
      check("R5 bad flag", 32'(hist_bad), 32'(v < 0));
      check("R9 idle before refill", 32'(victim_vld), 32'h0);
      refill_req = 1'b1;
      step();
      check("R7 answer valid", 32'(victim_vld), 32'h1);
      check("R7 error", 32'(victim_err), 32'(v < 0));
      check("R4 victim", 32'(victim_idx), (v < 0) ? 32'h0 : 32'(v));
      check("R7 history after refill", 32'(hist),
            (v < 0) ? 32'(h) : 32'(ref_touch(6'(h), v)));
      step();
      check("R7 single pulse", 32'(victim_vld), 32'h0);
      for (int w = 0; w < 4; w++) begin
        load(6'(h));
        touch_vld = 1'b1; touch_idx = 2'(w);
        step();
        check("R6 touch", 32'(hist), 32'(ref_touch(6'(h), w)));
        step();
        check("R9 hold", 32'(hist), 32'(ref_touch(6'(h), w)));
      end
    end

    // R8: refill and touch together; only the refill updates.
    load(6'b111000);
    refill_req = 1'b1; touch_vld = 1'b1; touch_idx = 2'd3;
    step();
    check("R8 refill wins", 32'(hist), 32'(ref_touch(6'b111000, 0)));
    check("R8 victim", 32'(victim_idx), 32'h0);

    // R2: write beats refill and touch in the same cycle.
    load(6'b000000);
    cfg_wr = 1'b1; cfg_wdata = {6'b101010, 26'h3FF_FFFF};
    refill_req = 1'b1; touch_vld = 1'b1; touch_idx = 2'd1;
    step();
    check("R2 write precedence", 32'(hist), 32'b101010);
    check("R7 answer from old history", 32'(victim_idx), 32'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule